// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block collects up to eight interrupt request lines, keeps a pending register, a mask register and an in-service register, and raises one interrupt output towards a processor. Line 0 has the highest priority and line 7 the lowest; this order is fixed. A pending line is offered only when no line of equal or higher priority is already in service. The processor answers with an acknowledge pulse. The controller then marks the winning line as in service, drops its pending bit and returns an interrupt vector.

Software drives the block through a byte-wide register port with a single address bit. Writing an initialization command puts the controller back into a known state. The controller then takes three further setup words in a fixed order: the vector base, the cascade word and the mode word. Only after the third of them does it resume normal operation. In normal operation the port writes the mask, sends a non-specific end-of-interrupt command, and chooses which register a read returns. Line 2 is the input from a downstream controller, so masking it silences every request from that controller.

The vector leaves on a valid/ready channel. `vec_valid` rises one cycle after an accepted acknowledge. It holds, with `vec_data` unchanged, until the cycle in which `vec_ready` is high. An acknowledge that arrives while a vector is still waiting is dropped.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset `irq_out` and `vec_valid` are 0 and the mask reads 00h. No request raises `irq_out`, and no acknowledge is accepted, until the full initialization sequence has been written.
- R2: A write with `wr_a0`=0 and data bit 4 = 1 is an initialization command, accepted at any time. It clears the mask, pending and in-service registers and selects the pending register for reads. The next three writes with `wr_a0`=1 are taken as vector base, cascade word and mode word, in that order, and none of them changes the mask. Normal operation begins only after the third.
- R3: Bit 3 of the initialization command selects the trigger. With 1 (level), a pending bit follows its input line. With 0 (edge), a pending bit is set on a rising edge and stays set until it is acknowledged, even while the line stays high.
- R4: In normal operation a write with `wr_a0`=1 loads the mask. A bit of 1 blocks that line and a bit of 0 lets it through. A read with `rd_a0`=1 returns the mask.
- R5: With mask bit 2 set, activity on line 2 (the cascade input from a downstream controller) never raises `irq_out`. The request stays pending and is offered once bit 2 is cleared.
- R6: `irq_out` is 1 exactly when the lowest-numbered unmasked pending line has a lower number than every set in-service bit.
- R7: An accepted acknowledge with `irq_out`=1 returns vector {base[7:3], line number}, clears that pending bit and, in normal-EOI mode, sets its in-service bit. With `irq_out`=0 it returns {base[7:3], 3'd7} and changes no in-service bit.
- R8: `vec_valid` and `vec_data` hold until `vec_ready` is 1. An acknowledge while `vec_valid`=1 is ignored.
- R9: Mode word bit 1 = 1 selects automatic end-of-interrupt. An acknowledge then leaves the in-service register unchanged.
- R10: A write with `wr_a0`=0, data bits 4:3 = 00 and bits 7:5 = 001 is a non-specific end-of-interrupt. It clears the lowest-numbered set in-service bit.
- R11: A write with `wr_a0`=0, data bit 4 = 0 and bit 3 = 1 sets the read selection. Bits 1:0 = 10 select pending and 11 select in-service; any other value leaves the selection unchanged. A read with `rd_a0`=0 returns the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_a0 | input | 1 | Register write address bit |
| wr_data | input | 8 | Register write data |
| rd_a0 | input | 1 | Register read address bit |
| rd_data | output | 8 | Register read data (combinational) |
| irq_in | input | 8 | Interrupt request lines; line 2 is the cascade input |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | Vector available |
| vec_ready | input | 1 | Vector consumer ready |
| vec_data | output | 8 | Interrupt vector |

## Verification
The assertions assume the following about the inputs:
- `wr_en` is a single-cycle strobe.
- An acknowledge and an end-of-interrupt write never fall in the same cycle, or the in-service checks would see two updates at once.
- Request lines change only between clock edges, away from the sampling edge.

The directed tasks keep to these rules. They drive every input on the falling edge, keep `ack` and `wr_en` apart, and release the vector channel before they acknowledge again.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BASE = 3'd1,
    ST_CASC = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } seq_st_e;

  localparam int INIT_BIT    = 4;
  localparam int TRIG_BIT    = 3;
  localparam int AUTOEOI_BIT = 1;
  localparam int OCW3_BIT    = 3;
  localparam logic [2:0] EOI_NS_CODE = 3'b001;
endpackage

// File: rtl/pic8_prio_enc.sv
module pic8_prio_enc #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/pic8_init_seq.sv
module pic8_init_seq
  import pic8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_a0,
  input  logic [DATA_W-1:0] wr_data,
  output logic              init_hit,
  output logic              run,
  output logic              level_mode,
  output logic              auto_eoi,
  output logic [DATA_W-1:0] vec_base
);
  seq_st_e st;

  assign init_hit = wr_en & ~wr_a0 & wr_data[INIT_BIT];
  assign run      = (st == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      level_mode <= 1'b0;
      auto_eoi   <= 1'b0;
      vec_base   <= '0;
    end else if (init_hit) begin
      st         <= ST_BASE;
      level_mode <= wr_data[TRIG_BIT];
      auto_eoi   <= 1'b0;
    end else if (wr_en && wr_a0) begin
      unique case (st)
        ST_BASE: begin vec_base <= wr_data; st <= ST_CASC; end
        ST_CASC: st <= ST_MODE;
        ST_MODE: begin auto_eoi <= wr_data[AUTOEOI_BIT]; st <= ST_RUN; end
        default: st <= st;
      endcase
    end
  end

  AST_SEQ_BASE_TO_CASC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BASE && wr_en && wr_a0) |=> (st == ST_CASC)); // R2
  AST_SEQ_MODE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MODE && wr_en && wr_a0) |=> run); // R2
endmodule

// File: rtl/pic8_req_latch.sv
module pic8_req_latch #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines,
  input  logic               level_mode,
  input  logic               clr,
  input  logic [N_LINES-1:0] ack_clr,
  output logic [N_LINES-1:0] pend
);
  logic [N_LINES-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      prev <= '0;
    end else begin
      prev <= lines;
      if (clr)             pend <= '0;
      else if (level_mode) pend <= lines;
      else                 pend <= (pend & ~ack_clr) | (lines & ~prev);
    end
  end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
  import pic8_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_a0,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_a0,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [N_LINES-1:0] irq_in,
  output logic               irq_out,
  input  logic               ack,
  output logic               vec_valid,
  input  logic               vec_ready,
  output logic [DATA_W-1:0]  vec_data
);
  logic init_hit, run, level_mode, auto_eoi;
  logic [DATA_W-1:0]  vec_base;
  logic [N_LINES-1:0] irr, isr, imr, ack_clr;
  logic               sel_isr;
  logic               p_any, s_any;
  logic [IDX_W-1:0]   p_idx, s_idx;

  pic8_init_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
    .init_hit(init_hit), .run(run), .level_mode(level_mode),
    .auto_eoi(auto_eoi), .vec_base(vec_base)
  );

  pic8_req_latch #(.N_LINES(N_LINES)) u_req (
    .clk(clk), .rst_n(rst_n), .lines(irq_in), .level_mode(level_mode),
    .clr(init_hit), .ack_clr(ack_clr), .pend(irr)
  );

  pic8_prio_enc #(.N_LINES(N_LINES)) u_pend_enc (
    .req(irr & ~imr), .any(p_any), .idx(p_idx)
  );

  pic8_prio_enc #(.N_LINES(N_LINES)) u_svc_enc (
    .req(isr), .any(s_any), .idx(s_idx)
  );

  assign irq_out = run && p_any && (!s_any || p_idx < s_idx);

  logic mask_we, ocw_we, eoi_ns, sel_we, ack_take;
  assign mask_we  = run & wr_en & wr_a0;
  assign ocw_we   = run & wr_en & ~wr_a0 & ~wr_data[INIT_BIT];
  assign eoi_ns   = ocw_we & ~wr_data[OCW3_BIT] & (wr_data[7:5] == EOI_NS_CODE);
  assign sel_we   = ocw_we & wr_data[OCW3_BIT] & wr_data[1];
  assign ack_take = ack & ~vec_valid & run;
  assign ack_clr  = (ack_take && irq_out) ? (N_LINES'(1) << p_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr     <= '0;
      sel_isr <= 1'b0;
    end else if (init_hit) begin
      imr     <= '0;
      sel_isr <= 1'b0;
    end else begin
      if (mask_we) imr     <= wr_data[N_LINES-1:0];
      if (sel_we)  sel_isr <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0;
    end else if (init_hit) begin
      isr <= '0;
    end else begin
      isr <= (isr & ~((eoi_ns && s_any) ? (N_LINES'(1) << s_idx) : '0))
           | (auto_eoi ? '0 : ack_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else if (ack_take) begin
      vec_valid <= 1'b1;
      vec_data  <= {vec_base[DATA_W-1:IDX_W], irq_out ? p_idx : IDX_W'(N_LINES - 1)};
    end else if (vec_ready) begin
      vec_valid <= 1'b0;
    end
  end

  assign rd_data = rd_a0 ? DATA_W'(imr) : DATA_W'(sel_isr ? isr : irr);

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_data))); // R8
  AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    init_hit |=> (imr == '0 && isr == '0)); // R2
  AST_ONE_NEW_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr & ~$past(isr)) <= 1)); // R7
  AST_AUTOEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_eoi && ack_take && !eoi_ns && !init_hit) |=> (isr == $past(isr))); // R9
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && isr != '0 && !ack_take) |=> ($countones(isr) + 1 == $countones($past(isr)))); // R10
  AST_NO_IRQ_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(run) || run); // R1
endmodule

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_a0 = 1'b0, rd_a0 = 1'b0, ack = 1'b0, vec_ready = 1'b0;
  logic [7:0] wr_data = '0, irq_in = '0;
  logic [7:0] rd_data, vec_data;
  logic irq_out, vec_valid;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic8_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
    .rd_a0(rd_a0), .rd_data(rd_data), .irq_in(irq_in), .irq_out(irq_out),
    .ack(ack), .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a0, input logic [7:0] d);
    wr_en = 1'b1; wr_a0 = a0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic a0, output logic [7:0] d);
    rd_a0 = a0; #1; d = rd_data;
  endtask

  task automatic setup(input logic lvl, input logic aeoi, input logic [7:0] base);
    reg_wr(1'b0, 8'h11 | (lvl ? 8'h08 : 8'h00));
    reg_wr(1'b1, base);
    reg_wr(1'b1, 8'h04);
    reg_wr(1'b1, 8'h01 | (aeoi ? 8'h02 : 8'h00));
  endtask

  task automatic do_ack(output logic [7:0] v);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    v = vec_data;
    chk("R8 vec_valid after ack", {7'd0, vec_valid}, 8'h01);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
    chk("R1 vec_valid after reset", {7'd0, vec_valid}, 8'h00);
    reg_rd(1'b1, d);
    chk("R1 mask after reset", d, 8'h00);
    irq_in = 8'h01;
    @(negedge clk);
    chk("R1 no irq before setup", {7'd0, irq_out}, 8'h00);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R1 ack ignored before setup", {7'd0, vec_valid}, 8'h00);
    irq_in = 8'h00;
    @(negedge clk);
  endtask

  task automatic t_init_seq;
    logic [7:0] d;
    setup(1'b0, 1'b0, 8'h40);
    reg_wr(1'b1, 8'hFF);
    reg_rd(1'b1, d);
    chk("R4 mask write", d, 8'hFF);
    reg_wr(1'b0, 8'h11);
    reg_rd(1'b1, d);
    chk("R2 init clears mask", d, 8'h00);
    reg_wr(1'b1, 8'h55);
    reg_rd(1'b1, d);
    chk("R2 base word not mask", d, 8'h00);
    irq_in = 8'h01; @(negedge clk);
    chk("R2 no irq mid-sequence", {7'd0, irq_out}, 8'h00);
    irq_in = 8'h00;
    reg_wr(1'b1, 8'h04);
    reg_wr(1'b1, 8'h01);
    reg_wr(1'b1, 8'h3C);
    reg_rd(1'b1, d);
    chk("R2 mask works after mode word", d, 8'h3C);
  endtask

  task automatic t_edge_prio;
    logic [7:0] d, v;
    setup(1'b0, 1'b0, 8'h40);
    irq_in = 8'h28; @(negedge clk);
    chk("R6 irq_out with pending", {7'd0, irq_out}, 8'h01);
    reg_rd(1'b0, d);
    chk("R3 edge pending", d, 8'h28);
    do_ack(v);
    chk("R7 vector line 3", v, 8'h43);
    reg_wr(1'b0, 8'h0B);
    reg_rd(1'b0, d);
    chk("R11 read in-service", d, 8'h08);
    reg_wr(1'b0, 8'h08);
    reg_rd(1'b0, d);
    chk("R11 other selection keeps", d, 8'h08);
    reg_wr(1'b0, 8'h0A);
    reg_rd(1'b0, d);
    chk("R7 pending bit cleared", d, 8'h20);
    chk("R6 lower line blocked", {7'd0, irq_out}, 8'h00);
    reg_wr(1'b0, 8'h20);
    chk("R10 eoi releases line 5", {7'd0, irq_out}, 8'h01);
    do_ack(v);
    chk("R7 vector line 5", v, 8'h45);
    reg_wr(1'b0, 8'h20);
    reg_rd(1'b0, d);
    chk("R3 edge not refired while high", d, 8'h00);
    chk("R3 no irq while line held", {7'd0, irq_out}, 8'h00);
    irq_in = 8'h00; @(negedge clk);
    do_ack(v);
    chk("R7 spurious vector", v, 8'h47);
    reg_wr(1'b0, 8'h0B);
    reg_rd(1'b0, d);
    chk("R7 spurious leaves in-service", d, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d;
    setup(1'b1, 1'b0, 8'h80);
    irq_in = 8'h10; @(negedge clk);
    reg_rd(1'b0, d);
    chk("R3 level pending", d, 8'h10);
    irq_in = 8'h00; @(negedge clk);
    reg_rd(1'b0, d);
    chk("R3 level follows line", d, 8'h00);
    chk("R3 level irq drops", {7'd0, irq_out}, 8'h00);
  endtask

  task automatic t_cascade;
    logic [7:0] d, v;
    setup(1'b0, 1'b0, 8'h20);
    reg_wr(1'b1, 8'h04);
    irq_in = 8'h04; @(negedge clk);
    chk("R5 cascade masked", {7'd0, irq_out}, 8'h00);
    reg_rd(1'b0, d);
    chk("R5 cascade still pending", d, 8'h04);
    reg_wr(1'b1, 8'h00);
    chk("R4 unmask raises irq", {7'd0, irq_out}, 8'h01);
    do_ack(v);
    chk("R5 cascade vector", v, 8'h22);
    reg_wr(1'b0, 8'h20);
    irq_in = 8'h00; @(negedge clk);
  endtask

  task automatic t_backpressure;
    logic [7:0] d, v0;
    setup(1'b0, 1'b0, 8'h60);
    irq_in = 8'h42; @(negedge clk);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    v0 = vec_data;
    chk("R8 first vector", v0, 8'h61);
    repeat (2) @(negedge clk);
    chk("R8 valid held", {7'd0, vec_valid}, 8'h01);
    chk("R8 data held", vec_data, v0);
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    chk("R8 second ack dropped", vec_data, 8'h61);
    vec_ready = 1'b1; @(negedge clk); vec_ready = 1'b0;
    chk("R8 valid clears on ready", {7'd0, vec_valid}, 8'h00);
    reg_wr(1'b0, 8'h0B);
    reg_rd(1'b0, d);
    chk("R8 one in-service bit only", d, 8'h02);
    irq_in = 8'h00; @(negedge clk);
  endtask

  task automatic t_autoeoi;
    logic [7:0] d, v;
    setup(1'b0, 1'b1, 8'hA0);
    irq_in = 8'h40; @(negedge clk);
    do_ack(v);
    chk("R9 auto eoi vector", v, 8'hA6);
    reg_wr(1'b0, 8'h0B);
    reg_rd(1'b0, d);
    chk("R9 in-service empty", d, 8'h00);
    irq_in = 8'h00; @(negedge clk);
    irq_in = 8'h80; @(negedge clk);
    chk("R9 next line offered", {7'd0, irq_out}, 8'h01);
    irq_in = 8'h00; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init_seq();
    t_edge_prio();
    t_level();
    t_cascade();
    t_backpressure();
    t_autoeoi();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule